// File: doc/BRIEF.md
# Multi-Chain Mux-Scan State Register Bank

This block holds a bank of state bits for a piece of synchronous logic and makes every one of them reachable from the pins for manufacturing test. Each bit is an edge-triggered D flip-flop with a 2:1 multiplexer in front of it. One multiplexer leg takes the bit's functional next-state value. The other takes the output of the preceding cell in its scan chain. The bits are split into several independent chains, and each chain may have its own length. Each chain has a dedicated serial input and a serial output.

A single mode input, `scanEnN`, controls every chain at once. While it is high, every flip-flop loads its bit of the parallel next-state bus on each clock. While it is low, every chain moves one place per clock, from its serial input towards its tail. The serial inputs arrive on pins that also serve as ordinary functional inputs elsewhere. The serial outputs leave on the functional output pins: a mode-selected multiplexer places the chain tails on those pins during shift and passes the functional outputs through otherwise.

All flip-flops run from the one ungated clock. A synchronous reset clears the whole bank whatever the mode.

Top module: `scan_bank`

## Requirements
- R1: When `rst` is high at a rising clock edge, every bit of `presentState` is 0 after that edge, regardless of `scanEnN`, `nextState` and `scanIn`.
- R2: When `rst` is low and `scanEnN` is 1 at a rising edge, `presentState` equals the value `nextState` had at that edge; `scanIn` has no effect.
- R3: When `rst` is low and `scanEnN` is 0 at a rising edge, each chain moves one place. Position 0 of chain c takes `scanIn[c]`, and every other position takes the old value of the position just below it. `nextState` has no effect.
- R4: Chain c has length L(c), read from the 8-bit field c of `ChainLens`; field c occupies bits 8c+7..8c. Chain c holds flat state bits B(c) to B(c)+L(c)-1, where B(c) is the sum of the lengths of chains 0..c-1. Position 0 is the lowest of those bits and sits next to the serial input. The defaults are lengths 5, 3 and 4, held in bits 0-4, 5-7 and 8-11.
- R5: While `scanEnN` is 0, `sharedOut[c]` shows the highest-position bit of chain c, which is flat bit B(c)+L(c)-1.
- R6: While `scanEnN` is 1, `sharedOut` equals `funcOut` combinationally, including while `rst` is high.
- R7: Start from a cleared bank and keep `scanEnN` at 0. A 1 presented on `scanIn[c]` at one edge, followed by 0s, first appears on `sharedOut[c]` after exactly L(c) edges, counting the edge at which it entered. All chains do this independently and at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for every flip-flop in the bank |
| rst | input | 1 | Synchronous reset, active high, clears all state |
| scanEnN | input | 1 | Mode select: 0 shifts all chains, 1 captures `nextState` |
| nextState | input | StateWidth (12) | Parallel functional next-state bus |
| scanIn | input | NumChains (3) | Serial input of each chain, shared with functional input pins |
| funcOut | input | NumChains (3) | Functional primary outputs that share pins with the chain tails |
| presentState | output | StateWidth (12) | Current contents of all state bits |
| sharedOut | output | NumChains (3) | Shared output pins: chain tails in shift mode, `funcOut` in capture mode |

## Verification
Reset can land in the same cycle as a capture or a shift. To provoke this, the bench raises `rst` once while `scanEnN` is 1 with an all-ones `nextState`, and once while shifting with all-ones serial inputs. It then judges that the bank reads all zeros on the next cycle while `sharedOut` still follows the mode. Mode changes on consecutive edges are also exercised. A phase that alternates capture and shift on every clock checks that data loaded by one capture moves one chain place on the very next edge. Throughout, a behavioural queue model of each chain is compared with `presentState` and `sharedOut` on every clock.

// File: rtl/scan_bank_pkg.sv
package scan_bank_pkg;

  localparam int unsigned MaxChains = 16;
  localparam int unsigned LenBits   = 8;
  localparam int unsigned LensW     = MaxChains * LenBits;

  typedef struct packed {
    logic clear;     // synchronous clear of every cell
    logic capture;   // load the functional next-state bus
    logic shift;     // move each chain one place
    logic funcView;  // shared pins show functional outputs
  } scanStrobe_t;

  function automatic int unsigned chainLen(input logic [LensW-1:0] lens,
                                           input int unsigned c);
    return int'(lens[c*LenBits +: LenBits]);
  endfunction

  function automatic int unsigned chainBase(input logic [LensW-1:0] lens,
                                            input int unsigned c);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < c; i++) acc += chainLen(lens, i);
    return acc;
  endfunction

endpackage

// File: rtl/scan_bank_ctrl.sv
module scan_bank_ctrl
  import scan_bank_pkg::*;
(
  input  logic        rst,
  input  logic        scanEnN,
  output scanStrobe_t strobe
);

  always_comb begin
    strobe.clear    = rst;
    strobe.capture  = !rst && scanEnN;
    strobe.shift    = !rst && !scanEnN;
    strobe.funcView = scanEnN;
  end

endmodule

// File: rtl/scan_bank_datapath.sv
module scan_bank_datapath
  import scan_bank_pkg::*;
#(
  parameter int unsigned          NumChains  = 3,
  parameter logic [LensW-1:0]     ChainLens  = LensW'(24'h04_03_05),
  parameter int unsigned          StateWidth = 12
) (
  input  logic                  clk,
  input  scanStrobe_t           strobe,
  input  logic [StateWidth-1:0] nextState,
  input  logic [NumChains-1:0]  scanIn,
  input  logic [NumChains-1:0]  funcOut,
  output logic [StateWidth-1:0] presentState,
  output logic [NumChains-1:0]  sharedOut
);

  logic [StateWidth-1:0] cellQ;
  logic [NumChains-1:0]  chainTail;

  for (genvar c = 0; c < NumChains; c++) begin : g_chain
    localparam int unsigned Base = chainBase(ChainLens, c);
    localparam int unsigned Len  = chainLen(ChainLens, c);

    for (genvar p = 0; p < Len; p++) begin : g_cell
      localparam int unsigned Idx = Base + p;
      logic shiftSrc;
      logic cellD;

      if (p == 0) begin : g_head
        assign shiftSrc = scanIn[c];
      end else begin : g_body
        assign shiftSrc = cellQ[Idx-1];
      end

      // mux-D scan cell: serial leg in shift mode, functional leg otherwise
      assign cellD = strobe.shift ? shiftSrc : nextState[Idx];

      always_ff @(posedge clk) begin
        if (strobe.clear) begin
          cellQ[Idx] <= 1'b0;
        end else if (strobe.capture || strobe.shift) begin
          cellQ[Idx] <= cellD;
        end
      end
    end

    assign chainTail[c] = cellQ[Base+Len-1];
    // pin sharing: tail drives the functional output pin during shift
    assign sharedOut[c] = strobe.funcView ? funcOut[c] : chainTail[c];
  end

  assign presentState = cellQ;

endmodule

// File: rtl/scan_bank.sv
module scan_bank
  import scan_bank_pkg::*;
#(
  parameter int unsigned                  NumChains  = 3,
  parameter logic [NumChains*LenBits-1:0] ChainLens  = 24'h04_03_05,
  localparam int unsigned                 StateWidth = chainBase(LensW'(ChainLens), NumChains)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scanEnN,
  input  logic [StateWidth-1:0] nextState,
  input  logic [NumChains-1:0]  scanIn,
  input  logic [NumChains-1:0]  funcOut,
  output logic [StateWidth-1:0] presentState,
  output logic [NumChains-1:0]  sharedOut
);

  scanStrobe_t strobe;

  scan_bank_ctrl ctrl_i (
    .rst     (rst),
    .scanEnN (scanEnN),
    .strobe  (strobe)
  );

  scan_bank_datapath #(
    .NumChains  (NumChains),
    .ChainLens  (LensW'(ChainLens)),
    .StateWidth (StateWidth)
  ) dp_i (
    .clk          (clk),
    .strobe       (strobe),
    .nextState    (nextState),
    .scanIn       (scanIn),
    .funcOut      (funcOut),
    .presentState (presentState),
    .sharedOut    (sharedOut)
  );

endmodule

// File: rtl/scan_bank_checker.sv
module scan_bank_checker
  import scan_bank_pkg::*;
#(
  parameter int unsigned                  NumChains  = 3,
  parameter logic [NumChains*LenBits-1:0] ChainLens  = 24'h04_03_05,
  localparam int unsigned                 StateWidth = chainBase(LensW'(ChainLens), NumChains)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scanEnN,
  input logic [StateWidth-1:0] nextState,
  input logic [NumChains-1:0]  scanIn,
  input logic [NumChains-1:0]  funcOut,
  input logic [StateWidth-1:0] presentState,
  input logic [NumChains-1:0]  sharedOut
);

  localparam logic [LensW-1:0] Lens = LensW'(ChainLens);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> presentState == '0);

  assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
    scanEnN |=> presentState == $past(nextState));

  always_comb begin
    if (scanEnN) begin
      assert_funcout_R6: assert (sharedOut == funcOut);
    end
  end

  for (genvar c = 0; c < NumChains; c++) begin : g_chk
    localparam int unsigned Base = chainBase(Lens, c);
    localparam int unsigned Len  = chainLen(Lens, c);

    // head of chain c sits at flat bit Base (R4 mapping)
    assert_shift_head_R3: assert property (@(posedge clk) disable iff (rst)
      !scanEnN |=> presentState[Base] == $past(scanIn[c]));

    always_comb begin
      if (!scanEnN) begin
        assert_scanout_R5: assert (sharedOut[c] == presentState[Base+Len-1]);
      end
    end

    for (genvar p = 1; p < Len; p++) begin : g_pos
      assert_shift_body_R3: assert property (@(posedge clk) disable iff (rst)
        !scanEnN |=> presentState[Base+p] == $past(presentState[Base+p-1]));
    end
  end

endmodule

bind scan_bank scan_bank_checker #(
  .NumChains (NumChains),
  .ChainLens (ChainLens)
) checker_i (.*);

// File: tb/tb_scan_bank.sv
module tb_scan_bank;

  localparam int NC = 3;
  localparam int SW = 12;
  localparam int LEN [NC]  = '{5, 3, 4};
  localparam int BASE [NC] = '{0, 5, 8};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scanEnN = 1'b1;
  logic [SW-1:0] nextState = '0;
  logic [NC-1:0] scanIn = '0;
  logic [NC-1:0] funcOut = '0;
  logic [SW-1:0] presentState;
  logic [NC-1:0] sharedOut;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  bit chainQ [NC][$];

  always #5 clk = ~clk;

  scan_bank dut (
    .clk(clk), .rst(rst), .scanEnN(scanEnN), .nextState(nextState),
    .scanIn(scanIn), .funcOut(funcOut), .presentState(presentState),
    .sharedOut(sharedOut)
  );

  initial begin
    for (int c = 0; c < NC; c++) begin
      for (int p = 0; p < LEN[c]; p++) chainQ[c].push_back(1'b0);
    end
  end

  // behavioural model: one queue per chain, element 0 = next to serial input
  always @(posedge clk) begin
    for (int c = 0; c < NC; c++) begin
      if (rst) begin
        for (int p = 0; p < LEN[c]; p++) chainQ[c][p] = 1'b0;
      end else if (scanEnN) begin
        for (int p = 0; p < LEN[c]; p++) chainQ[c][p] = nextState[BASE[c]+p];
      end else begin
        chainQ[c].push_front(scanIn[c]);
        void'(chainQ[c].pop_back());
      end
    end
  end

  function automatic logic [SW-1:0] modelState();
    logic [SW-1:0] v;
    v = '0;
    for (int c = 0; c < NC; c++)
      for (int p = 0; p < LEN[c]; p++) v[BASE[c]+p] = chainQ[c][p];
    return v;
  endfunction

  function automatic logic [NC-1:0] modelPins();
    logic [NC-1:0] v;
    for (int c = 0; c < NC; c++) v[c] = scanEnN ? funcOut[c] : chainQ[c][LEN[c]-1];
    return v;
  endfunction

  task automatic compareNow();
    logic [SW-1:0] expS;
    logic [NC-1:0] expP;
    expS = modelState();
    expP = modelPins();
    compared++;
    if (presentState !== expS) begin
      mismatched++;
      $display("FAIL %s presentState got %h exp %h", curReq, presentState, expS);
    end
    compared++;
    if (sharedOut !== expP) begin
      mismatched++;
      $display("FAIL %s sharedOut (%s) got %b exp %b", curReq,
               scanEnN ? "R6" : "R5", sharedOut, expP);
    end
  endtask

  task automatic step(input bit r, input bit en, input logic [SW-1:0] ns,
                      input logic [NC-1:0] si, input logic [NC-1:0] fo);
    rst = r; scanEnN = en; nextState = ns; scanIn = si; funcOut = fo;
    #1;
    compareNow();
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired during %s", curReq);
    finishRun();
  end

  initial begin
    int firstSeen [NC];
    @(negedge clk);
    // R1: reset with capture of all ones pending
    curReq = "R1";
    for (int i = 0; i < 3; i++) step(1, 1, '1, '1, 3'b101);
    // R2 / R6: parallel capture with varied patterns
    curReq = "R2";
    step(0, 1, 12'hA5C, 3'b010, 3'b110);
    step(0, 1, 12'h000, 3'b111, 3'b001);
    step(0, 1, 12'hFFF, 3'b000, 3'b011);
    for (int i = 0; i < 20; i++) step(0, 1, SW'($urandom), NC'($urandom), NC'($urandom));
    // R3 / R4 / R5: shift 0011 patterns, random next-state ignored
    curReq = "R3";
    for (int i = 0; i < 30; i++) begin
      logic b;
      b = ((i / 2) % 2) == 1;
      step(0, 0, SW'($urandom), {b, ~b, b}, NC'($urandom));
    end
    // R4: capture a walking pattern then shift it out
    curReq = "R4";
    step(0, 1, 12'b1000_1001_0001, 3'b000, 3'b000);
    for (int i = 0; i < 6; i++) step(0, 0, 12'hFFF, 3'b000, 3'b111);
    // R2 / R3: mode changes on consecutive edges
    curReq = "R3";
    for (int i = 0; i < 20; i++) step(0, i[0], SW'($urandom), NC'($urandom), NC'($urandom));
    // R1: reset in the same cycle as a shift of ones
    curReq = "R1";
    step(0, 0, '0, '1, '0);
    step(1, 0, '1, '1, '0);
    step(0, 1, '0, '0, 3'b100);
    // R7: latency of a single marker through every chain
    curReq = "R7";
    step(1, 0, '0, '0, '0);
    for (int c = 0; c < NC; c++) firstSeen[c] = -1;
    for (int i = 0; i < 8; i++) begin
      rst = 0; scanEnN = 0; nextState = '1; scanIn = (i == 0) ? '1 : '0; funcOut = '0;
      #1;
      compareNow();
      for (int c = 0; c < NC; c++)
        if (sharedOut[c] && firstSeen[c] < 0) firstSeen[c] = i;
      @(negedge clk);
    end
    for (int c = 0; c < NC; c++) begin
      compared++;
      if (firstSeen[c] != LEN[c]) begin
        mismatched++;
        $display("FAIL R7 chain %0d marker after %0d edges exp %0d", c, firstSeen[c], LEN[c]);
      end
    end
    finishRun();
  end

endmodule